// File: doc/BRIEF.md
# Non-Maskable Interrupt Sequencer

This block takes the active-low non-maskable interrupt pin of a small 8-bit processor core and turns a falling edge on it into an ordered acknowledge sequence. The pin passes through a two-flop synchronizer. A falling edge is then caught in a pending latch, and the latch stays set until the core reaches its sampling point. That point is a strobe marking the state just before T3 or T1, and it only counts during the last machine cycle of an instruction. Once the request has been sampled, the sequence starts at the next end-of-machine-cycle strobe.

The sequence runs its steps in a fixed order. First it asks for the DMA master-enable bit to be cleared and waits until that bit reads low. Next it requests a push of the program counter and waits for the push to complete. It then moves the live maskable-interrupt enable into the shadow flag and clears the live flag. Last, it presents the fixed restart address 0x0066 until the core takes it. A separate return-from-NMI event copies the shadow flag back into the live flag and requests a pop of the stacked program counter.

Top module: `nmi_seq_ctrl`

## Requirements
- R1: After reset, `ief1` and `ief2` are 0, no request output (`dma_clr`, `push_req`, `vec_valid`, `pop_req`, `nmi_ack`) is high, and the pending latch is empty.
- R2: `nmi_n` is edge sensitive. One high-to-low transition produces exactly one acknowledge, however long the pin then stays low. Rising edges and steady levels produce none. A latched edge is held until it is sampled.
- R3: The pending request is sampled only in a cycle where `mc_last` and `t_sample` are both high. The sequence starts at the next clock edge that sees `mc_end` high, and `nmi_ack` is high for exactly the one cycle that follows that edge.
- R4: The first step is `dma_clr`. It is high from the start of the sequence until `dma_en` is seen low, and it is raised even when `dma_en` is high (transfer in progress).
- R5: The second step is `push_req`. It is raised only after `dma_en` has been seen low, and it stays high until a cycle with `push_done` high.
- R6: After the push, one cycle copies `ief1` into `ief2` and clears `ief1` to 0.
- R7: The last step holds `vec_valid` high with `vec_addr` = 0x0066 until `vec_taken` is seen high. The block then goes idle. At most one of `dma_clr`, `push_req`, `vec_valid` is high at a time.
- R8: A `retn` pulse copies `ief2` into `ief1` at the next edge and raises `pop_req` for one cycle.
- R9: A falling edge that arrives while a sequence runs is latched anew. It produces a second, separate acknowledge after the next valid sampling point.
- R10: `ei` sets both flags and `di` clears both. When events coincide, the priority is: save step, then `retn`, then `di`, then `ei`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_n | input | 1 | Asynchronous active-low NMI pin |
| mc_last | input | 1 | Current machine cycle is the last of the instruction |
| t_sample | input | 1 | Strobe for the state before T3/T1 |
| mc_end | input | 1 | Strobe for the final clock of the machine cycle |
| dma_en | input | 1 | Current DMA master-enable bit |
| dma_clr | output | 1 | Request to clear the DMA master-enable bit |
| push_req | output | 1 | Request to push the program counter |
| push_done | input | 1 | Push completed |
| vec_valid | output | 1 | Restart address valid |
| vec_addr | output | 16 | Restart address (0x0066) |
| vec_taken | input | 1 | Core has taken the restart address |
| retn | input | 1 | Return-from-NMI executed |
| pop_req | output | 1 | Request to pop the program counter |
| ei | input | 1 | Enable maskable interrupts |
| di | input | 1 | Disable maskable interrupts |
| ief1 | output | 1 | Live maskable-interrupt enable |
| ief2 | output | 1 | Shadow enable |
| nmi_ack | output | 1 | One-cycle pulse when a sequence starts |

## Verification
The pin is driven in four ways: a short low pulse, a long low level, rising edges alone, and a second falling edge that lands in the middle of a running sequence. Each pattern is judged by how many acknowledges it produces, which tells edge detection apart from level detection and tells a fresh latch apart from a merged one. The sampling strobes are applied in machine cycles with and without `mc_last`, which shows whether the sample point gates the start. The handshake latencies are varied so that every step can be seen holding for more than one cycle. The enable flags are set up through `ei`, `di` and `retn` both before and after sequences, so that the save and restore are checked with both a 0 and a 1 value.

// File: rtl/nmi_seq_pkg.sv
// Shared types for the NMI sequencer. Assumes nothing beyond 1800-2017.
package nmi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DMA,
        ST_PUSH,
        ST_SAVE,
        ST_VEC
    } seq_state_t;
endpackage

// File: rtl/nmi_edge_latch.sv
// Synchronizes the active-low NMI pin and latches a falling edge.
// Assumes SYNC_STAGES >= 2. A new edge wins over a clear in the same cycle.
module nmi_edge_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clear,
    output logic pending
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;
    logic         fall;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[MSB-1:0], nmi_n};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[MSB];
    end

    assign fall = prev_q & ~sync_q[MSB];

    // Hold a detected edge until the sequencer consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (fall)  pending <= 1'b1;
        else if (clear) pending <= 1'b0;
    end
endmodule

// File: rtl/nmi_ack_fsm.sv
// Samples the pending request at the core's sample point and steps through
// the acknowledge: DMA off, PC push, flag save, vector. Each step waits for
// its handshake. Assumes the strobes are single-cycle pulses from the core.
module nmi_ack_fsm
    import nmi_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic mc_last,
    input  logic t_sample,
    input  logic mc_end,
    input  logic dma_en,
    input  logic push_done,
    input  logic vec_taken,
    output logic latch_clr,
    output logic nmi_ack,
    output logic dma_clr,
    output logic push_req,
    output logic save_pulse,
    output logic vec_valid,
    output logic seq_busy
);
    seq_state_t state, state_nx;
    logic       armed;
    logic       start;

    assign start     = (state == ST_IDLE) && armed && mc_end;
    assign latch_clr = start;

    // Arm on the sample point of the last machine cycle; disarm on start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (start)
            armed <= 1'b0;
        else if (state == ST_IDLE && pending && mc_last && t_sample)
            armed <= 1'b1;
    end

    // Next-state selection for the acknowledge steps.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)     state_nx = ST_DMA;
            ST_DMA:  if (!dma_en)   state_nx = ST_PUSH;
            ST_PUSH: if (push_done) state_nx = ST_SAVE;
            ST_SAVE:                state_nx = ST_VEC;
            ST_VEC:  if (vec_taken) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // State register and one-cycle acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nmi_ack <= 1'b0;
        end else begin
            state   <= state_nx;
            nmi_ack <= start;
        end
    end

    assign dma_clr    = (state == ST_DMA);
    assign push_req   = (state == ST_PUSH);
    assign save_pulse = (state == ST_SAVE);
    assign vec_valid  = (state == ST_VEC);
    assign seq_busy   = (state != ST_IDLE);
endmodule

// File: rtl/nmi_ief_flags.sv
// Live and shadow maskable-interrupt enable flags. Priority: save, return,
// disable, enable. Return also raises a one-cycle pop request.
module nmi_ief_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic save,
    input  logic retn,
    input  logic ei,
    input  logic di,
    output logic ief1,
    output logic ief2,
    output logic pop_req
);
    // Update both flags according to the event priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ief1 <= 1'b0;
            ief2 <= 1'b0;
        end else if (save) begin
            ief2 <= ief1;
            ief1 <= 1'b0;
        end else if (retn) begin
            ief1 <= ief2;
        end else if (di) begin
            ief1 <= 1'b0;
            ief2 <= 1'b0;
        end else if (ei) begin
            ief1 <= 1'b1;
            ief2 <= 1'b1;
        end
    end

    // Pop request follows a return event by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pop_req <= 1'b0;
        else        pop_req <= retn;
    end
endmodule

// File: rtl/nmi_seq_ctrl.sv
// Top of the NMI sequencer: edge latch, acknowledge FSM and enable flags.
// Assumes all inputs except nmi_n are synchronous to clk.
module nmi_seq_ctrl #(
    parameter int              SYNC_STAGES = 2,
    parameter int              VEC_W       = 16,
    parameter logic [VEC_W-1:0] RESTART    = 16'h0066
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_n,
    input  logic             mc_last,
    input  logic             t_sample,
    input  logic             mc_end,
    input  logic             dma_en,
    output logic             dma_clr,
    output logic             push_req,
    input  logic             push_done,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_addr,
    input  logic             vec_taken,
    input  logic             retn,
    output logic             pop_req,
    input  logic             ei,
    input  logic             di,
    output logic             ief1,
    output logic             ief2,
    output logic             nmi_ack
);
    logic pending;
    logic latch_clr;
    logic save_pulse;
    logic seq_busy;

    nmi_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .clear   (latch_clr),
        .pending (pending)
    );

    nmi_ack_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .mc_last    (mc_last),
        .t_sample   (t_sample),
        .mc_end     (mc_end),
        .dma_en     (dma_en),
        .push_done  (push_done),
        .vec_taken  (vec_taken),
        .latch_clr  (latch_clr),
        .nmi_ack    (nmi_ack),
        .dma_clr    (dma_clr),
        .push_req   (push_req),
        .save_pulse (save_pulse),
        .vec_valid  (vec_valid),
        .seq_busy   (seq_busy)
    );

    nmi_ief_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .save    (save_pulse),
        .retn    (retn),
        .ei      (ei),
        .di      (di),
        .ief1    (ief1),
        .ief2    (ief2),
        .pop_req (pop_req)
    );

    assign vec_addr = vec_valid ? RESTART : '0;
endmodule

// File: rtl/nmi_seq_ctrl_chk.sv
// Protocol checks for the NMI sequencer, attached by bind.
module nmi_seq_ctrl_chk #(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_en,
    input logic             dma_clr,
    input logic             push_req,
    input logic             push_done,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_addr,
    input logic             vec_taken,
    input logic             retn,
    input logic             pop_req,
    input logic             ief1,
    input logic             ief2,
    input logic             nmi_ack,
    input logic             seq_busy
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |=> !nmi_ack); // R3
    AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_clr && dma_en) |=> dma_clr); // R4
    AST_PUSH_AFTER_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_req) |-> $past(!dma_en)); // R5
    AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_done) |=> push_req); // R5
    AST_SAVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> (!ief1 && ief2 == $past(ief1))); // R6
    AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> vec_addr == 16'h0066); // R7
    AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_clr, push_req, vec_valid})); // R7
    AST_RETN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (retn && !seq_busy) |=> (pop_req && ief1 == $past(ief2))); // R8
endmodule

bind nmi_seq_ctrl nmi_seq_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_en    (dma_en),
    .dma_clr   (dma_clr),
    .push_req  (push_req),
    .push_done (push_done),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .vec_taken (vec_taken),
    .retn      (retn),
    .pop_req   (pop_req),
    .ief1      (ief1),
    .ief2      (ief2),
    .nmi_ack   (nmi_ack),
    .seq_busy  (seq_busy)
);

// File: tb/nmi_seq_ctrl_test.sv
`timescale 1ns/1ps
module nmi_seq_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_n = 1'b1, mc_last = 1'b0, t_sample = 1'b0, mc_end = 1'b0;
    logic dma_en = 1'b0, push_done = 1'b0, vec_taken = 1'b0;
    logic retn = 1'b0, ei = 1'b0, di = 1'b0;
    logic dma_clr, push_req, vec_valid, pop_req, ief1, ief2, nmi_ack;
    logic [15:0] vec_addr;

    int vectors = 0, fails = 0, acks = 0, cycles = 0;
    int dma_lat = 1, push_lat = 1, vec_lat = 1, wait_cnt = 0;

    // reference model state
    bit pinq[$];
    int m_st = 0;
    bit m_pend, m_armed, m_ack, m_i1, m_i2, m_pop;

    always #2.5 clk = ~clk;

    nmi_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .mc_last(mc_last),
        .t_sample(t_sample), .mc_end(mc_end), .dma_en(dma_en),
        .dma_clr(dma_clr), .push_req(push_req), .push_done(push_done),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_taken(vec_taken),
        .retn(retn), .pop_req(pop_req), .ei(ei), .di(di),
        .ief1(ief1), .ief2(ief2), .nmi_ack(nmi_ack)
    );

    // Behavioural reference: sequence steps 0 idle,1 dma,2 push,3 save,4 vector.
    always @(posedge clk) begin
        if (!rst_n) begin
            pinq = '{1, 1, 1};
            m_st = 0; m_pend = 0; m_armed = 0; m_ack = 0;
            m_i1 = 0; m_i2 = 0; m_pop = 0;
        end else begin
            bit fall, start;
            fall  = pinq[pinq.size()-3] && !pinq[pinq.size()-2];
            start = (m_st == 0) && m_armed && mc_end;
            if (start) m_armed = 0;
            else if (m_st == 0 && m_pend && mc_last && t_sample) m_armed = 1;
            if (fall) m_pend = 1; else if (start) m_pend = 0;
            m_ack = start;
            m_pop = retn;
            if (m_st == 3) begin m_i2 = m_i1; m_i1 = 0; end
            else if (retn) m_i1 = m_i2;
            else if (di) begin m_i1 = 0; m_i2 = 0; end
            else if (ei) begin m_i1 = 1; m_i2 = 1; end
            case (m_st)
                0: if (start) m_st = 1;
                1: if (!dma_en) m_st = 2;
                2: if (push_done) m_st = 3;
                3: m_st = 4;
                4: if (vec_taken) m_st = 0;
                default: m_st = 0;
            endcase
            pinq.push_back(nmi_n);
            if (pinq.size() > 3) void'(pinq.pop_front());
        end
    end

    task automatic cmp(string req, string what, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: compare at negedge, then update responders and clear pulses.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        if (nmi_ack) acks++;
        cmp("R3", "nmi_ack", {15'd0, nmi_ack}, {15'd0, m_ack});
        cmp("R4", "dma_clr", {15'd0, dma_clr}, {15'd0, m_st == 1});
        cmp("R5", "push_req", {15'd0, push_req}, {15'd0, m_st == 2});
        cmp("R7", "vec_valid", {15'd0, vec_valid}, {15'd0, m_st == 4});
        if (vec_valid) cmp("R7", "vec_addr", vec_addr, 16'h0066);
        cmp("R6", "ief1", {15'd0, ief1}, {15'd0, m_i1});
        cmp("R6", "ief2", {15'd0, ief2}, {15'd0, m_i2});
        cmp("R8", "pop_req", {15'd0, pop_req}, {15'd0, m_pop});
        t_sample = 0; mc_end = 0; retn = 0; ei = 0; di = 0;
        push_done = 0; vec_taken = 0;
        if (dma_clr || push_req || vec_valid) wait_cnt++; else wait_cnt = 0;
        if (dma_clr && wait_cnt >= dma_lat) begin dma_en = 0; wait_cnt = 0; end
        if (push_req && wait_cnt >= push_lat) begin push_done = 1; wait_cnt = 0; end
        if (vec_valid && wait_cnt >= vec_lat) begin vec_taken = 1; wait_cnt = 0; end
    endtask

    task automatic mcycle(bit last);
        mc_last = last; tick();
        t_sample = 1; tick();
        mc_end = 1; tick();
        mc_last = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_nmi(int width);
        nmi_n = 0; idle(width); nmi_n = 1;
    endtask

    // Watchdog: expiry counts as a failure and still reaches the summary.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(2);
        // R1: reset state
        cmp("R1", "ief1", {15'd0, ief1}, 16'd0);
        cmp("R1", "ief2", {15'd0, ief2}, 16'd0);
        cmp("R1", "requests", {12'd0, dma_clr, push_req, vec_valid, pop_req}, 16'd0);
        mcycle(1);
        cmp("R1", "no ack without edge", acks[15:0], 16'd0);

        // R10: enable sets both flags
        ei = 1; tick();
        cmp("R10", "ei both", {14'd0, ief1, ief2}, 16'd3);

        // R2/R3/R4: short pulse, DMA active, sampled in a non-last cycle first
        dma_en = 1; dma_lat = 3;
        pulse_nmi(2); idle(3);
        mcycle(0);
        cmp("R3", "no ack outside last cycle", acks[15:0], 16'd0);
        mcycle(1); idle(12);
        cmp("R2", "one ack per edge", acks[15:0], 16'd1);
        cmp("R6", "saved flags", {14'd0, ief1, ief2}, 16'd1);

        // R8: return restores
        retn = 1; tick();
        cmp("R8", "restore ief1", {15'd0, ief1}, 16'd1);

        // R2: long low level gives one acknowledge; rising edge gives none
        a0 = acks;
        nmi_n = 0; idle(4);
        mcycle(1); idle(10); mcycle(1); idle(10);
        nmi_n = 1; idle(4); mcycle(1); idle(4);
        cmp("R2", "level low single ack", acks[15:0], a0[15:0] + 16'd1);
        retn = 1; tick();

        // R9: new edge during the running sequence, slow handshakes
        a0 = acks;
        push_lat = 6; vec_lat = 4; dma_en = 1;
        pulse_nmi(2); idle(3); mcycle(1);
        idle(2); pulse_nmi(2); idle(14);
        cmp("R9", "first ack only", acks[15:0], a0[15:0] + 16'd1);
        mcycle(1); idle(16);
        cmp("R9", "second ack separate", acks[15:0], a0[15:0] + 16'd2);

        // R10: disable clears both; then an NMI saves a 0
        di = 1; tick();
        cmp("R10", "di both", {14'd0, ief1, ief2}, 16'd0);
        pulse_nmi(2); idle(3); mcycle(1); idle(16);
        cmp("R6", "save zero", {14'd0, ief1, ief2}, 16'd0);

        // R10: retn beats ei in the same cycle
        ei = 1; tick();
        di = 1; retn = 0; tick();
        retn = 1; ei = 1; tick();
        cmp("R10", "retn over ei", {15'd0, ief1}, 16'd0);
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule